// File: doc/BRIEF.md
# Carry-Chain Equality Comparator

This block is a purely combinational identity comparator for two unsigned vectors of parameterised width. A static parameter selects the sense of the single output: high when the operands match, or high when they differ. The logic is spelled out as explicit truth-table cells and 2:1 carry multiplexer cells, the same structure a slice-based programmable fabric would use.

Narrow operands of one or two bits are resolved inside a single lookup cell whose truth table already encodes the selected sense. Wider operands are split into bit pairs, starting at the least significant bit. Each pair has its own 4-input lookup that flags a pair match. That flag steers a carry multiplexer. When the width is odd, the top bit gets a 2-input lookup. The chain lookups always test for a match. The not-equal sense comes from swapping the constants on the multiplexer data inputs and on the bottom carry-in, so no inverter sits after the last multiplexer.

Top module: `eq_carry_cmp`

## Requirements
- R1: With WIDTH=1 and NE_MODE=0, q_o is 1 exactly when a_i equals b_i. A single 2-input lookup with truth table 0x9 produces it, with a_i on input 0 and b_i on input 1.
- R2: With WIDTH=1 and NE_MODE=1, q_o is 1 exactly when a_i differs from b_i. A single 2-input lookup with truth table 0x6 produces it.
- R3: With WIDTH=2, one 4-input lookup drives q_o. Its inputs 0 to 3 are a_i[0], b_i[0], a_i[1], b_i[1]. Its table is 0x9009 when NE_MODE=0 and 0x6FF6 when NE_MODE=1.
- R4: With WIDTH of 3 or more and NE_MODE=0, q_o equals (a_i == b_i) for every input pair.
- R5: With WIDTH of 3 or more and NE_MODE=1, q_o equals (a_i != b_i) for every input pair. The chain lookups still test for a match.
- R6: With an odd WIDTH, a mismatch confined to the most significant bit is detected by the single-bit top slice.
- R7: A mismatch at any single bit position, from the least to the most significant, drives q_o to the constant data input of the multiplexers. That constant is 0 when NE_MODE=0 and 1 when NE_MODE=1.
- R8: When all bits match, q_o carries the chain's bottom carry-in through unchanged. The carry-in is 1 when NE_MODE=0 and 0 when NE_MODE=1.
- R9: The block holds no state. q_o reflects new inputs in the same time step, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| q_o | output | 1 | Comparison result, in the sense set by NE_MODE |

## Verification
Every result is due in the same time step as its stimulus, zero cycles later, because no register lies between the operands and q_o. The bench changes the operands just after a rising edge and reads q_o at the following falling edge. The chain has therefore settled, and no check races a clock edge. A single shared pair of operand buses drives several instances at once: widths 1 to 6 are swept exhaustively and width 32 gets random and single-bit-flip patterns, all in both senses.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam logic [15:0] LUT_EQ1 = 16'h0009;
  localparam logic [15:0] LUT_NE1 = 16'h0006;
  localparam logic [15:0] LUT_EQ2 = 16'h9009;
  localparam logic [15:0] LUT_NE2 = 16'h6FF6;
endpackage

// File: rtl/lut_cell.sv
module lut_cell #(
  parameter logic [15:0] INIT = 16'h0000
) (
  input  logic i0,
  input  logic i1,
  input  logic i2,
  input  logic i3,
  output logic o
);
  always_comb o = INIT[{i3, i2, i1, i0}];
endmodule

// File: rtl/carry_mux.sv
module carry_mux (
  input  logic sel_i,
  input  logic ci_i,
  input  logic di_i,
  output logic co_o
);
  // select high propagates carry from below
  always_comb co_o = sel_i ? ci_i : di_i;
endmodule

// File: rtl/eq_chain.sv
module eq_chain #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          NE_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             q_o
);
  import cmp_pkg::*;

  localparam int unsigned NSLICE = (WIDTH + 1) / 2;
  localparam logic        DI_VAL = NE_MODE ? 1'b1 : 1'b0;
  localparam logic        CI_VAL = NE_MODE ? 1'b0 : 1'b1;

  logic [NSLICE-1:0] sel;
  logic [NSLICE:0]   carry;

  assign carry[0] = CI_VAL;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    if (2*k + 1 < WIDTH) begin : g_pair
      lut_cell #(.INIT(LUT_EQ2)) u_lut (
        .i0(a_i[2*k]), .i1(b_i[2*k]), .i2(a_i[2*k+1]), .i3(b_i[2*k+1]),
        .o (sel[k])
      );
      always_comb begin
        a_r4_pair_match: assert (sel[k] == (a_i[2*k+1:2*k] == b_i[2*k+1:2*k]))
          else $error("pair lookup mismatch at slice %0d", k);
      end
    end else begin : g_single
      lut_cell #(.INIT(LUT_EQ1)) u_lut (
        .i0(a_i[2*k]), .i1(b_i[2*k]), .i2(1'b0), .i3(1'b0),
        .o (sel[k])
      );
      always_comb begin
        a_r6_top_bit_match: assert (sel[k] == (a_i[2*k] == b_i[2*k]))
          else $error("top single-bit lookup wrong");
      end
    end

    carry_mux u_mux (
      .sel_i(sel[k]),
      .ci_i (carry[k]),
      .di_i (DI_VAL),
      .co_o (carry[k+1])
    );
  end

  assign q_o = carry[NSLICE];

  always_comb begin
    if (!(&sel)) begin
      a_r7_mismatch_forces_di: assert (q_o == DI_VAL)
        else $error("mismatch did not force data constant");
    end else begin
      a_r8_match_passes_ci: assert (q_o == CI_VAL)
        else $error("full match did not pass bottom carry");
    end
  end
endmodule

// File: rtl/eq_carry_cmp.sv
module eq_carry_cmp #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          NE_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             q_o
);
  import cmp_pkg::*;

  if (WIDTH == 1) begin : g_w1
    lut_cell #(.INIT(NE_MODE ? LUT_NE1 : LUT_EQ1)) u_lut (
      .i0(a_i[0]), .i1(b_i[0]), .i2(1'b0), .i3(1'b0), .o(q_o)
    );
  end else if (WIDTH == 2) begin : g_w2
    lut_cell #(.INIT(NE_MODE ? LUT_NE2 : LUT_EQ2)) u_lut (
      .i0(a_i[0]), .i1(b_i[0]), .i2(a_i[1]), .i3(b_i[1]), .o(q_o)
    );
  end else begin : g_chain
    eq_chain #(.WIDTH(WIDTH), .NE_MODE(NE_MODE)) u_chain (
      .a_i(a_i), .b_i(b_i), .q_o(q_o)
    );
  end

  // R1 R2 R3 R4 R5: end-to-end sense of the result
  always_comb begin
    a_r5_result_sense: assert (q_o == (NE_MODE ? (a_i != b_i) : (a_i == b_i)))
      else $error("comparison result wrong");
  end
endmodule

// File: tb/eq_carry_cmp_tb.sv
module eq_carry_cmp_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] a_drv, b_drv;
  logic [6:1]  q_eq, q_ne;
  logic        q32_eq, q32_ne;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  for (genvar w = 1; w <= 6; w++) begin : g_w
    eq_carry_cmp #(.WIDTH(w), .NE_MODE(1'b0)) u_eq (
      .a_i(a_drv[w-1:0]), .b_i(b_drv[w-1:0]), .q_o(q_eq[w]));
    eq_carry_cmp #(.WIDTH(w), .NE_MODE(1'b1)) u_ne (
      .a_i(a_drv[w-1:0]), .b_i(b_drv[w-1:0]), .q_o(q_ne[w]));
  end

  eq_carry_cmp #(.WIDTH(32), .NE_MODE(1'b0)) u_dut (
    .a_i(a_drv), .b_i(b_drv), .q_o(q32_eq));
  eq_carry_cmp #(.WIDTH(32), .NE_MODE(1'b1)) u_dut_ne (
    .a_i(a_drv), .b_i(b_drv), .q_o(q32_ne));

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h got=%b exp=%b", req, a_drv, b_drv, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    #0.5;
    a_drv = a;
    b_drv = b;
    @(negedge clk);
  endtask

  task automatic t_initial_state;
    apply(32'h0, 32'h0);
    check(q32_eq, 1'b1, "R8 zero operands eq");
    check(q32_ne, 1'b0, "R8 zero operands ne");
  endtask

  task automatic t_exhaustive;
    for (int w = 1; w <= 6; w++) begin
      for (int a = 0; a < (1 << w); a++) begin
        for (int b = 0; b < (1 << w); b++) begin
          apply(32'(a), 32'(b));
          if (w == 1) begin
            check(q_eq[w], a == b, "R1 width1 eq");
            check(q_ne[w], a != b, "R2 width1 ne");
          end else if (w == 2) begin
            check(q_eq[w], a == b, "R3 width2 eq");
            check(q_ne[w], a != b, "R3 width2 ne");
          end else begin
            check(q_eq[w], a == b, "R4 chain eq");
            check(q_ne[w], a != b, "R5 chain ne");
          end
        end
      end
    end
  endtask

  task automatic t_single_flip;
    logic [31:0] base;
    base = 32'hA5C3_1E78;
    for (int p = 0; p < 32; p++) begin
      apply(base, base ^ (32'h1 << p));
      check(q32_eq, 1'b0, "R7 flip eq");
      check(q32_ne, 1'b1, "R7 flip ne");
    end
    for (int p = 0; p < 5; p++) begin
      apply(32'h15, 32'h15 ^ (32'h1 << p));
      check(q_eq[5], 1'b0, "R7 w5 flip eq");
      check(q_ne[5], 1'b1, "R7 w5 flip ne");
    end
  endtask

  task automatic t_odd_top_bit;
    apply(32'h10, 32'h00);
    check(q_eq[5], 1'b0, "R6 w5 top bit eq");
    check(q_ne[5], 1'b1, "R6 w5 top bit ne");
    apply(32'h04, 32'h00);
    check(q_eq[3], 1'b0, "R6 w3 top bit eq");
    check(q_ne[3], 1'b1, "R6 w3 top bit ne");
  endtask

  task automatic t_all_equal;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      v = $urandom;
      apply(v, v);
      check(q32_eq, 1'b1, "R8 match eq");
      check(q32_ne, 1'b0, "R8 match ne");
    end
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check(q32_eq, 1'b1, "R8 all ones eq");
  endtask

  task automatic t_random;
    logic [31:0] a, b;
    for (int i = 0; i < 1000; i++) begin
      a = $urandom;
      b = (i % 2 == 0) ? a : $urandom;
      apply(a, b);
      check(q32_eq, a == b, "R4 random eq");
      check(q32_ne, a != b, "R5 random ne");
    end
  endtask

  task automatic t_no_clock;
    // R9: result follows operands without any clock edge
    @(negedge clk);
    a_drv = 32'h1234_5678;
    b_drv = 32'h1234_5678;
    #0.5;
    check(q32_eq, 1'b1, "R9 comb eq");
    b_drv = 32'h1234_5679;
    #0.5;
    check(q32_eq, 1'b0, "R9 comb ne change");
    check(q32_ne, 1'b1, "R9 comb ne");
  endtask

  initial begin
    a_drv = '0;
    b_drv = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_initial_state();
    t_exhaustive();
    t_single_flip();
    t_odd_top_bit();
    t_all_equal();
    t_random();
    t_no_clock();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule